// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block fills the four threshold registers that a pair of opposing FIFOs use to raise their almost-full and almost-empty flags. The mode pins are read once, on the first port-A clock edge after the master reset is released. That single reading selects one of three load methods. The first loads a fixed preset into all four offsets at once. The second takes the offsets from the first four port-A data writes. The third takes them from a 40-bit serial stream that is clocked in while an active-low enable pin is held low.

The registers always load in the order Y1, X1, Y2, X2. Y1 is the port-A almost-full offset, X1 the port-B almost-empty offset, Y2 the port-B almost-full offset and X2 the port-A almost-empty offset. A completion signal holds off the write-ready flag of each port until the load has finished. Port-A write strobes reach the FIFO storage only after that point. The storage itself lies outside this block.

Top module: `ofs_load_ctrl`

## Requirements
- R1: The mode is decoded on the first rising edge of clk_a_i after rst_ni goes high, and it stays fixed until the next reset. With mode_sel_i high and either select pin high, the mode is preset. With mode_sel_i high and both select pins low, the mode is parallel. With mode_sel_i low, the mode is serial.
- R2: In preset mode, all four offsets take the same value on the decode edge. With sel1_sen_ni and sel0_sd_i both high the value is 64. With only sel1_sen_ni high it is 16. With only sel0_sd_i high it is 8.
- R3: In parallel mode, the first four port-A writes after decode load wr_data_i into the offsets in the order Y1 (afull_a_o), X1 (aempty_b_o), Y2 (afull_b_o), X2 (aempty_a_o). A port-A write is a rising edge with wr_strobe_i high. Bit OFS_W-1 of wr_data_i is the MSB, so each offset covers 0 to 1023.
- R4: fifo_wr_o follows wr_strobe_i in the same cycle only while load_done_o is high. Writes that are used to load offsets, and writes made before completion, never reach the storage.
- R5: In serial mode, each rising edge of clk_a_i with sel1_sen_ni low shifts sel0_sd_i into the chain {Y1,X1,Y2,X2}, entering at the LSB of X2. The offset outputs show the chain as it fills. After 40 shifts, the first bit is the MSB of Y1 and the last bit is the LSB of X2.
- R6: Once load_done_o is high, the offsets no longer change. Serial-enable pulses beyond the 40th bit and further port-A writes have no effect on them.
- R7: load_done_o rises on the decode edge in preset mode. In parallel mode it rises on the edge of the fourth load write, and in serial mode on the edge of the 40th bit. ready_a_o is high whenever load_done_o is high, and also from the decode edge onward in parallel mode. In serial mode ready_a_o stays low until completion. Both signals remain high until reset.
- R8: ready_b_o is low until completion and rises on the second rising edge of clk_b_i after load_done_o rises.
- R9: While rst_ni is low, and until the decode edge, all offsets are 0 and load_done_o, ready_a_o, ready_b_o and fifo_wr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port-A clock; decode, loading and ready_a_o |
| clk_b_i | input | 1 | Port-B clock; ready_b_o |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| mode_sel_i | input | 1 | High: preset or parallel mode; low: serial mode |
| sel0_sd_i | input | 1 | Preset select bit 0; serial data after decode |
| sel1_sen_ni | input | 1 | Preset select bit 1; active-low serial enable after decode |
| wr_strobe_i | input | 1 | Port-A qualified write strobe |
| wr_data_i | input | OFS_W | Low port-A data bits |
| afull_a_o | output | OFS_W | Y1: port-A almost-full offset |
| aempty_b_o | output | OFS_W | X1: port-B almost-empty offset |
| afull_b_o | output | OFS_W | Y2: port-B almost-full offset |
| aempty_a_o | output | OFS_W | X2: port-A almost-empty offset |
| load_done_o | output | 1 | Programming complete |
| ready_a_o | output | 1 | Port-A input-ready gate |
| ready_b_o | output | 1 | Port-B input-ready gate, in the clk_b_i domain |
| fifo_wr_o | output | 1 | Write strobe passed on to the storage |

## Verification
The preset offsets and load_done_o are due one edge after reset release, which is the decode edge. A parallel slot changes on the edge that samples its strobe, and each serial bit appears on the edge that shifts it in. In both modes completion is visible immediately after the last loading edge. ready_b_o follows two port-B edges later. fifo_wr_o is combinational, so it is checked in the same cycle as the strobe. The bench drives its inputs just after each falling edge, advances a behavioural model on each rising edge, and compares every output against that model at the next falling edge. Each comparison therefore sees exactly the register updates that the latest rising edge produced.

// File: rtl/ofs_load_pkg.sv
package ofs_load_pkg;
  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_PRESET = 2'd1,
    MODE_PAR    = 2'd2,
    MODE_SER    = 2'd3
  } load_mode_e;

  localparam int NUM_OFS = 4;  // slot order: Y1, X1, Y2, X2
endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
  import ofs_load_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int P_BOTH = 64,
  parameter int P_HI   = 16,
  parameter int P_LO   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_sel_i,
  input  logic             sel0_i,
  input  logic             sel1_i,
  output load_mode_e       mode_o,
  output logic [OFS_W-1:0] preset_o
);
  load_mode_e       mode_q;
  logic [OFS_W-1:0] preset_q;

  // mode latched once on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_NONE;
      preset_q <= '0;
    end else if (mode_q == MODE_NONE) begin
      if (!mode_sel_i) begin
        mode_q <= MODE_SER;
      end else if (sel0_i || sel1_i) begin
        mode_q <= MODE_PRESET;
        if (sel0_i && sel1_i) preset_q <= OFS_W'(P_BOTH);
        else if (sel1_i)      preset_q <= OFS_W'(P_HI);
        else                  preset_q <= OFS_W'(P_LO);
      end else begin
        mode_q <= MODE_PAR;
      end
    end
  end

  assign mode_o   = mode_q;
  assign preset_o = preset_q;
endmodule

// File: rtl/ofs_par_load.sv
module ofs_par_load #(
  parameter int OFS_W = 10,
  parameter int NUM   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] data_i,
  output logic [OFS_W-1:0] ofs_o [NUM],
  output logic             done_o
);
  localparam int CNT_W = $clog2(NUM + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [OFS_W-1:0] ofs_q [NUM];
  logic             take;

  assign take = en_i && wr_i && (cnt_q != CNT_W'(NUM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < NUM; i++) ofs_q[i] <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      for (int i = 0; i < NUM; i++)
        if (cnt_q == CNT_W'(i)) ofs_q[i] <= data_i;
    end
  end

  assign ofs_o  = ofs_q;
  assign done_o = en_i && (cnt_q == CNT_W'(NUM));
endmodule

// File: rtl/ofs_serial_load.sv
module ofs_serial_load #(
  parameter int OFS_W = 10,
  parameter int NUM   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sen_ni,
  input  logic             sd_i,
  output logic [OFS_W-1:0] ofs_o [NUM],
  output logic             done_o
);
  localparam int TOTAL = NUM * OFS_W;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [TOTAL-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en_i && !sen_ni && (cnt_q != CNT_W'(TOTAL))) begin
      sh_q  <= {sh_q[TOTAL-2:0], sd_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // slot 0 (Y1) sits at the top of the chain
  for (genvar g = 0; g < NUM; g++) begin : g_slice
    assign ofs_o[g] = sh_q[TOTAL-1-g*OFS_W -: OFS_W];
  end

  assign done_o = en_i && (cnt_q == CNT_W'(TOTAL));
endmodule

// File: rtl/ofs_rdy_sync.sv
module ofs_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/ofs_load_ctrl.sv
module ofs_load_ctrl
  import ofs_load_pkg::*;
#(
  parameter int OFS_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             rst_ni,
  input  logic             mode_sel_i,
  input  logic             sel0_sd_i,
  input  logic             sel1_sen_ni,
  input  logic             wr_strobe_i,
  input  logic [OFS_W-1:0] wr_data_i,
  output logic [OFS_W-1:0] afull_a_o,
  output logic [OFS_W-1:0] aempty_b_o,
  output logic [OFS_W-1:0] afull_b_o,
  output logic [OFS_W-1:0] aempty_a_o,
  output logic             load_done_o,
  output logic             ready_a_o,
  output logic             ready_b_o,
  output logic             fifo_wr_o
);
  load_mode_e       mode;
  logic [OFS_W-1:0] preset;
  logic [OFS_W-1:0] par_ofs [NUM_OFS];
  logic [OFS_W-1:0] ser_ofs [NUM_OFS];
  logic [OFS_W-1:0] sel_ofs [NUM_OFS];
  logic             par_done, ser_done;

  ofs_mode_decode #(.OFS_W(OFS_W)) u_dec (
    .clk_i      (clk_a_i),
    .rst_ni     (rst_ni),
    .mode_sel_i (mode_sel_i),
    .sel0_i     (sel0_sd_i),
    .sel1_i     (sel1_sen_ni),
    .mode_o     (mode),
    .preset_o   (preset)
  );

  ofs_par_load #(.OFS_W(OFS_W), .NUM(NUM_OFS)) u_par (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .en_i   (mode == MODE_PAR),
    .wr_i   (wr_strobe_i),
    .data_i (wr_data_i),
    .ofs_o  (par_ofs),
    .done_o (par_done)
  );

  ofs_serial_load #(.OFS_W(OFS_W), .NUM(NUM_OFS)) u_ser (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .en_i   (mode == MODE_SER),
    .sen_ni (sel1_sen_ni),
    .sd_i   (sel0_sd_i),
    .ofs_o  (ser_ofs),
    .done_o (ser_done)
  );

  always_comb begin
    for (int i = 0; i < NUM_OFS; i++) begin
      unique case (mode)
        MODE_PRESET: sel_ofs[i] = preset;
        MODE_PAR:    sel_ofs[i] = par_ofs[i];
        MODE_SER:    sel_ofs[i] = ser_ofs[i];
        default:     sel_ofs[i] = '0;
      endcase
    end
  end

  assign afull_a_o  = sel_ofs[0];
  assign aempty_b_o = sel_ofs[1];
  assign afull_b_o  = sel_ofs[2];
  assign aempty_a_o = sel_ofs[3];

  assign load_done_o = (mode == MODE_PRESET) || par_done || ser_done;
  assign ready_a_o   = load_done_o || (mode == MODE_PAR);
  assign fifo_wr_o   = wr_strobe_i && load_done_o;

  ofs_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .d_i    (load_done_o),
    .q_o    (ready_b_o)
  );
endmodule

// File: rtl/ofs_load_chk.sv
module ofs_load_chk #(
  parameter int OFS_W = 10
) (
  input logic             clk_a_i,
  input logic             rst_ni,
  input logic [OFS_W-1:0] afull_a_o,
  input logic [OFS_W-1:0] aempty_b_o,
  input logic [OFS_W-1:0] afull_b_o,
  input logic [OFS_W-1:0] aempty_a_o,
  input logic             load_done_o,
  input logic             ready_a_o,
  input logic             ready_b_o
);
  p_offsets_frozen_r6: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    load_done_o |=> $stable({afull_a_o, aempty_b_o, afull_b_o, aempty_a_o}));

  p_done_sticky_r7: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    load_done_o |=> load_done_o);

  p_ready_a_sticky_r7: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ready_a_o |=> ready_a_o);

  p_ready_b_after_done_r8: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ready_b_o |-> load_done_o);

  p_ready_b_lags_r8: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $rose(ready_b_o) |-> $past(load_done_o));
endmodule

bind ofs_load_ctrl ofs_load_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_a_i     (clk_a_i),
  .rst_ni      (rst_ni),
  .afull_a_o   (afull_a_o),
  .aempty_b_o  (aempty_b_o),
  .afull_b_o   (afull_b_o),
  .aempty_a_o  (aempty_a_o),
  .load_done_o (load_done_o),
  .ready_a_o   (ready_a_o),
  .ready_b_o   (ready_b_o)
);

// File: tb/ofs_load_ctrl_tb.sv
module ofs_load_ctrl_tb;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         msel = 1'b0, s0 = 1'b0, s1 = 1'b0, stb = 1'b0;
  logic [W-1:0] dat = '0;
  logic [W-1:0] y1, x1, y2, x2;
  logic         done, rdy_a, rdy_b, fwr;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ofs_load_ctrl #(.OFS_W(W)) u_dut (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .mode_sel_i(msel), .sel0_sd_i(s0), .sel1_sen_ni(s1),
    .wr_strobe_i(stb), .wr_data_i(dat),
    .afull_a_o(y1), .aempty_b_o(x1), .afull_b_o(y2), .aempty_a_o(x2),
    .load_done_o(done), .ready_a_o(rdy_a), .ready_b_o(rdy_b), .fifo_wr_o(fwr)
  );

  // behavioural reference: 0 none, 1 preset, 2 parallel, 3 serial
  int          m_mode;
  int          m_cnt;
  int          m_ofs [4];
  logic [39:0] m_chain;
  bit          m_done, m_rb1, m_rb2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_chain = '0; m_done = 0; m_rb1 = 0; m_rb2 = 0;
      foreach (m_ofs[i]) m_ofs[i] = 0;
    end else begin
      m_rb2 = m_rb1;
      m_rb1 = m_done;
      if (m_mode == 0) begin
        if (!msel) m_mode = 3;
        else if (s0 || s1) begin
          m_mode = 1;
          foreach (m_ofs[i]) m_ofs[i] = (s0 && s1) ? 64 : (s1 ? 16 : 8);
        end else m_mode = 2;
      end else if (m_mode == 2 && stb && m_cnt < 4) begin
        m_ofs[m_cnt] = int'(dat);
        m_cnt++;
      end else if (m_mode == 3 && !s1 && m_cnt < 40) begin
        m_chain = {m_chain[38:0], s0};
        m_cnt++;
      end
      if (m_mode == 3) begin
        m_ofs[0] = int'(m_chain[39:30]); m_ofs[1] = int'(m_chain[29:20]);
        m_ofs[2] = int'(m_chain[19:10]); m_ofs[3] = int'(m_chain[9:0]);
      end
      m_done = (m_mode == 1) || (m_mode == 2 && m_cnt == 4) || (m_mode == 3 && m_cnt == 40);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string ofs_tag();
    if (m_mode == 0) return "R9";
    if (m_done) return "R6";
    if (m_mode == 1) return "R2";
    if (m_mode == 2) return "R3";
    return "R5";
  endfunction

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(ofs_tag(), "afull_a", int'(y1), m_ofs[0]);
      chk(ofs_tag(), "aempty_b", int'(x1), m_ofs[1]);
      chk(ofs_tag(), "afull_b", int'(y2), m_ofs[2]);
      chk(ofs_tag(), "aempty_a", int'(x2), m_ofs[3]);
      chk(m_mode == 0 ? "R9" : "R7", "load_done", int'(done), int'(m_done));
      chk(m_mode == 0 ? "R9" : "R7", "ready_a", int'(rdy_a), int'(m_done || m_mode == 2));
      chk(m_mode == 0 ? "R9" : "R8", "ready_b", int'(rdy_b), int'(m_rb2));
      chk(m_mode == 0 ? "R9" : "R4", "fifo_wr", int'(fwr), int'(stb && m_done));
    end
  end

  task automatic start(input logic ms, input logic a0, input logic a1);
    @(negedge clk); #1;
    rst_n = 1'b0; msel = ms; s0 = a0; s1 = a1; stb = 1'b0; dat = '0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;  // decode edge has passed
  endtask

  task automatic write(input logic [W-1:0] d);
    stb = 1'b1; dat = d;
    @(negedge clk); #1;
    stb = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      summary();
    end
  end

  logic [39:0] pat = 40'hB4_6D_29_F1_C7;

  initial begin
    // R1/R2 preset, both selects
    start(1'b1, 1'b1, 1'b1);
    chk("R2", "preset64", int'(y1), 64);
    chk("R1", "preset done", int'(done), 1);
    msel = 1'b0; s1 = 1'b0;  // mode pins after decode: no effect
    write(10'h155);
    repeat (3) @(negedge clk); #1;
    chk("R1", "mode held", int'(x2), 64);

    start(1'b1, 1'b0, 1'b1);
    chk("R2", "preset16", int'(aempty_a_val()), 16);
    start(1'b1, 1'b1, 1'b0);
    chk("R2", "preset8", int'(y2), 8);

    // parallel load
    start(1'b1, 1'b0, 1'b0);
    chk("R1", "par ready_a", int'(rdy_a), 1);
    chk("R9", "par not done", int'(done), 0);
    write(10'h3FF);
    @(negedge clk); #1;
    write(10'h2AA);
    write(10'h001);
    chk("R4", "no fifo write while loading", int'(fwr), 0);
    write(10'h200);
    chk("R3", "Y1", int'(y1), 10'h3FF);
    chk("R3", "X1", int'(x1), 10'h2AA);
    chk("R3", "Y2", int'(y2), 10'h001);
    chk("R3", "X2", int'(x2), 10'h200);
    write(10'h0F0);
    write(10'h00F);
    chk("R6", "Y1 after extra writes", int'(y1), 10'h3FF);
    repeat (3) @(negedge clk); #1;
    chk("R8", "ready_b up", int'(rdy_b), 1);

    // serial load
    start(1'b0, 1'b0, 1'b1);
    chk("R7", "serial ready_a low", int'(rdy_a), 0);
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 3) begin
        s1 = 1'b1; stb = 1'b1;
        @(negedge clk); #1;
        stb = 1'b0;
      end
      s1 = 1'b0; s0 = pat[39-i];
      @(negedge clk); #1;
    end
    s1 = 1'b1;
    chk("R5", "Y1 serial", int'(y1), int'(pat[39:30]));
    chk("R5", "X2 serial", int'(x2), int'(pat[9:0]));
    chk("R7", "serial done", int'(done), 1);
    chk("R8", "ready_b lag", int'(rdy_b), 0);
    s1 = 1'b0; s0 = 1'b1;
    repeat (5) @(negedge clk); #1;
    s1 = 1'b1;
    chk("R6", "X2 after extra bits", int'(x2), int'(pat[9:0]));
    chk("R8", "ready_b serial", int'(rdy_b), 1);
    summary();
  end

  function automatic logic [W-1:0] aempty_a_val();
    return x2;
  endfunction
endmodule